// File: doc/BRIEF.md
# GPIO Interrupt Detector and Line Router

This block turns 128 synchronized pin levels into latched interrupt events and drives three interrupt lines from them. Each pin has its own trigger configuration. Level detection fires while the pin sits at its active level. Edge detection fires on the transition into that level. A sense bit picks high or rising when it is 0, and low or falling when it is 1. Once an event is seen it sets a status bit. The status bit holds until software writes a one to it. A pending event always wins over a clear in the same cycle.

Each pin has an enable bit that gates its status into the interrupt lines. The top sixteen pins each carry a two-bit route select that sends the pin to the legacy line, to line A or to line B. Every lower pin feeds the legacy line. A pin that is driven as an output never sets its status bit, so the pin cannot loop back into an interrupt. Bus decoding is done elsewhere. The block takes the configuration vectors and the clear strobes directly.

Top module: `gpio_irq_router`

## Requirements
- R1: In level mode (`edge_mode_i` bit = 0), the status bit is set at each clock edge where the pin is at its active level: high when the `sense_i` bit is 0, low when it is 1.
- R2: In edge mode (`edge_mode_i` bit = 1), the status bit is set only at the clock edge that first sees a rising transition (`sense_i` = 0) or a falling transition (`sense_i` = 1). A transition in the other direction, or a steady level, does nothing.
- R3: A set status bit stays set while its clear strobe is low, even after the pin returns to its inactive level.
- R4: A one on `clr_i[i]` at a clock edge clears `status_o[i]`, as long as no event is pending for that pin at that edge.
- R5: When an event is pending at the same edge as a clear, the status bit ends up set.
- R6: A pin whose `oe_i` bit is 1 never sets its status bit, in either mode.
- R7: An interrupt line is high one clock after some pin routed to it has both its status bit and its `irq_en_i` bit set. It is low one clock after no such pin exists.
- R8: Pins 0 to 111 always feed `irq_legacy_o`.
- R9: Pin 112+k (k = 0..15) is routed by `route_sel_i[2k+1:2k]`: 00 goes to legacy, 01 to line A, 10 to line B, and 11 to legacy.
- R10: Reset clears the status vector and all three lines. A pin that is already at an edge-active level when reset is released produces no edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_lvl_i | input | 128 | Synchronized, polarity-adjusted pin levels |
| oe_i | input | 128 | Output-enable per pin; 1 masks the pin's events |
| edge_mode_i | input | 128 | 0 selects level detection, 1 selects edge detection |
| sense_i | input | 128 | 0 selects high/rising, 1 selects low/falling |
| irq_en_i | input | 128 | Per-pin enable into the interrupt lines |
| clr_i | input | 128 | Write-one-to-clear strobes for the status bits |
| route_sel_i | input | 32 | Two-bit route select for pins 112..127, pin 112 at [1:0] |
| status_o | output | 128 | Latched event status |
| irq_legacy_o | output | 1 | Legacy interrupt line |
| irq_a_o | output | 1 | Interrupt line A |
| irq_b_o | output | 1 | Interrupt line B |

## Verification
A pin or clear change applied before a clock edge shows up in `status_o` right after that edge. The interrupt lines follow one edge later, because they are registered from the status vector. The bench drives its inputs on the falling edge. It advances a behavioural reference model on the rising edge and compares every output on the next falling edge, so each result is sampled in the cycle it becomes due. The directed checks sample `status_o` one tick after a stimulus and the lines two ticks after a pin event, or one tick after an enable change.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    RT_LEGACY = 2'b00,
    RT_A      = 2'b01,
    RT_B      = 2'b10,
    RT_SPARE  = 2'b11
  } route_e;
endpackage

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
  parameter int N_PINS = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [N_PINS-1:0] oe_i,
  input  logic [N_PINS-1:0] edge_mode_i,
  input  logic [N_PINS-1:0] sense_i,
  output logic [N_PINS-1:0] evt_o
);
  logic [N_PINS-1:0] prev_q;
  logic              primed_q;

  // primed_q blocks edge compares until prev_q holds a real sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= lvl_i;
      primed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic act, edge_hit;
    assign act      = lvl_i[i] ^ sense_i[i];
    assign edge_hit = primed_q & (prev_q[i] ^ lvl_i[i]) & act;
    assign evt_o[i] = ~oe_i[i] & (edge_mode_i[i] ? edge_hit : act);
  end

  // R10
  no_edge_unprimed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_q |-> ((evt_o & edge_mode_i) == '0));
endmodule

// File: rtl/gpio_irq_status.sv
`timescale 1ns/1ps
module gpio_irq_status #(
  parameter int N_PINS = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] set_i,
  input  logic [N_PINS-1:0] clr_i,
  output logic [N_PINS-1:0] status_o
);
  logic [N_PINS-1:0] status_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end
  assign status_o = status_q;

  // R3
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_q) & ~$past(clr_i) & ~status_q) == '0));
  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_i) & ~status_q) == '0));
endmodule

// File: rtl/gpio_irq_route.sv
`timescale 1ns/1ps
module gpio_irq_route #(
  parameter int N_PINS   = 128,
  parameter int GRP_BASE = 112,
  parameter int GRP_PINS = 16,
  localparam int GRP_W   = 2 * GRP_PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] status_i,
  input  logic [N_PINS-1:0] en_i,
  input  logic [GRP_W-1:0]  sel_i,
  output logic              irq_legacy_o,
  output logic              irq_a_o,
  output logic              irq_b_o
);
  import gpio_irq_pkg::*;

  logic [N_PINS-1:0] live, to_leg, to_a, to_b;
  logic leg_q, a_q, b_q;

  assign live = status_i & en_i;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    if (i >= GRP_BASE && i < GRP_BASE + GRP_PINS) begin : g_grp
      route_e rt;
      assign rt        = route_e'(sel_i[2*(i-GRP_BASE) +: 2]);
      assign to_a[i]   = (rt == RT_A);
      assign to_b[i]   = (rt == RT_B);
      assign to_leg[i] = ~to_a[i] & ~to_b[i];
    end else begin : g_fix
      assign to_a[i]   = 1'b0;
      assign to_b[i]   = 1'b0;
      assign to_leg[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      leg_q <= 1'b0;
      a_q   <= 1'b0;
      b_q   <= 1'b0;
    end else begin
      leg_q <= |(live & to_leg);
      a_q   <= |(live & to_a);
      b_q   <= |(live & to_b);
    end
  end

  assign irq_legacy_o = leg_q;
  assign irq_a_o      = a_q;
  assign irq_b_o      = b_q;

  // R7
  quiet_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|live) |=> !(irq_legacy_o | irq_a_o | irq_b_o));
  // R8
  alt_lines_grp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_a_o | irq_b_o) |-> $past(|live[GRP_BASE+GRP_PINS-1:GRP_BASE]));
endmodule

// File: rtl/gpio_irq_router.sv
`timescale 1ns/1ps
module gpio_irq_router #(
  parameter int N_PINS   = 128,
  parameter int GRP_BASE = 112,
  parameter int GRP_PINS = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_PINS-1:0]       pin_lvl_i,
  input  logic [N_PINS-1:0]       oe_i,
  input  logic [N_PINS-1:0]       edge_mode_i,
  input  logic [N_PINS-1:0]       sense_i,
  input  logic [N_PINS-1:0]       irq_en_i,
  input  logic [N_PINS-1:0]       clr_i,
  input  logic [2*GRP_PINS-1:0]   route_sel_i,
  output logic [N_PINS-1:0]       status_o,
  output logic                    irq_legacy_o,
  output logic                    irq_a_o,
  output logic                    irq_b_o
);
  logic [N_PINS-1:0] evt;

  gpio_irq_detect #(.N_PINS(N_PINS)) u_det (
    .clk_i, .rst_ni, .lvl_i(pin_lvl_i), .oe_i, .edge_mode_i, .sense_i, .evt_o(evt)
  );

  gpio_irq_status #(.N_PINS(N_PINS)) u_st (
    .clk_i, .rst_ni, .set_i(evt), .clr_i, .status_o
  );

  gpio_irq_route #(.N_PINS(N_PINS), .GRP_BASE(GRP_BASE), .GRP_PINS(GRP_PINS)) u_rt (
    .clk_i, .rst_ni, .status_i(status_o), .en_i(irq_en_i), .sel_i(route_sel_i),
    .irq_legacy_o, .irq_a_o, .irq_b_o
  );

  // R6
  oe_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & ~$past(status_o) & $past(oe_i)) == '0));
endmodule

// File: tb/sim_gpio_irq_router.sv
`timescale 1ns/1ps
module sim_gpio_irq_router;
  localparam int N = 128;
  localparam int GB = 112;
  localparam int GP = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] pin = '0, oe = '0, emode = '0, sense = '0, en = '0, clr = '0;
  logic [2*GP-1:0] rsel = '0;
  logic [N-1:0] status;
  logic irq_l, irq_a, irq_b;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_irq_router u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pin_lvl_i(pin), .oe_i(oe), .edge_mode_i(emode),
    .sense_i(sense), .irq_en_i(en), .clr_i(clr), .route_sel_i(rsel),
    .status_o(status), .irq_legacy_o(irq_l), .irq_a_o(irq_a), .irq_b_o(irq_b)
  );

  // behavioural reference
  logic [N-1:0] m_prev, m_st;
  bit m_valid, m_l, m_a, m_b;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_prev = '0; m_st = '0; m_valid = 0; m_l = 0; m_a = 0; m_b = 0;
    end else begin
      logic [N-1:0] nst;
      bit l, a, b;
      l = 0; a = 0; b = 0;
      nst = m_st & ~clr;
      for (int p = 0; p < N; p++) begin
        bit active, hit;
        int route;
        active = sense[p] ? !pin[p] : pin[p];
        if (emode[p]) hit = m_valid && (m_prev[p] != pin[p]) && active;
        else          hit = active;
        if (hit && !oe[p]) nst[p] = 1'b1;
        route = 0;
        if (p >= GB) route = int'(rsel[2*(p-GB) +: 2]);
        if (m_st[p] && en[p]) begin
          if (route == 1) a = 1;
          else if (route == 2) b = 1;
          else l = 1;
        end
      end
      m_l = l; m_a = a; m_b = b;
      m_st = nst;
      m_prev = pin;
      m_valid = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk(status === m_st, "R1 R2 R3 R4 R5 R6 model status", status, m_st);
    chk({irq_l, irq_a, irq_b} === {m_l, m_a, m_b}, "R7 R8 R9 model lines",
        N'({irq_l, irq_a, irq_b}), N'({m_l, m_a, m_b}));
  endtask

  task automatic wipe();
    pin = '0; sense = '0; emode = '0; oe = '0; clr = '1;
    tick();
    clr = '0;
  endtask

  initial begin
    emode[7] = 1'b1;
    pin[7] = 1'b1;
    tick(); tick();
    chk(status === '0, "R10 status in reset", status, '0);
    chk({irq_l, irq_a, irq_b} === 3'b000, "R10 lines in reset", N'({irq_l, irq_a, irq_b}), '0);
    rst_ni = 1'b1;
    tick(); tick();
    chk(status[7] === 1'b0, "R10 no edge after release", N'(status[7]), '0);

    // level high, level low
    pin[3] = 1'b1;
    sense[4] = 1'b1;
    tick();
    chk(status[3] === 1'b1, "R1 level high", N'(status[3]), N'(1));
    chk(status[4] === 1'b1, "R1 level low", N'(status[4]), N'(1));
    pin[3] = 1'b0;
    tick();
    chk(status[3] === 1'b1, "R3 sticky after pin drops", N'(status[3]), N'(1));
    chk(irq_l === 1'b0, "R7 disabled pin no line", N'(irq_l), '0);
    en[3] = 1'b1;
    tick();
    chk(irq_l === 1'b1, "R7 line one tick after enable", N'(irq_l), N'(1));

    clr[3] = 1'b1;
    tick();
    clr[3] = 1'b0;
    chk(status[3] === 1'b0, "R4 clear", N'(status[3]), '0);
    tick();
    chk(irq_l === 1'b0, "R7 line drops after clear", N'(irq_l), '0);

    pin[3] = 1'b1;
    clr[3] = 1'b1;
    tick();
    clr[3] = 1'b0;
    chk(status[3] === 1'b1, "R5 pending wins over clear", N'(status[3]), N'(1));

    // edges
    emode[10] = 1'b1;
    pin[10] = 1'b1;
    tick();
    chk(status[10] === 1'b1, "R2 rising edge", N'(status[10]), N'(1));
    emode[11] = 1'b1;
    sense[11] = 1'b1;
    tick();
    chk(status[11] === 1'b0, "R2 falling mode steady low", N'(status[11]), '0);
    pin[11] = 1'b1;
    tick();
    chk(status[11] === 1'b0, "R2 falling mode ignores rise", N'(status[11]), '0);
    pin[11] = 1'b0;
    tick();
    chk(status[11] === 1'b1, "R2 falling edge", N'(status[11]), N'(1));

    oe[20] = 1'b1;
    pin[20] = 1'b1;
    tick(); tick();
    chk(status[20] === 1'b0, "R6 output pin masked", N'(status[20]), '0);

    // routing
    wipe();
    en = '1;
    rsel[1:0] = 2'b01;
    rsel[3:2] = 2'b10;
    rsel[5:4] = 2'b11;
    pin[112] = 1'b1;
    tick(); tick();
    chk({irq_l, irq_a, irq_b} === 3'b010, "R9 sel 01 to A", N'({irq_l, irq_a, irq_b}), N'(3'b010));
    wipe();
    pin[113] = 1'b1;
    tick(); tick();
    chk({irq_l, irq_a, irq_b} === 3'b001, "R9 sel 10 to B", N'({irq_l, irq_a, irq_b}), N'(3'b001));
    wipe();
    pin[114] = 1'b1;
    tick(); tick();
    chk({irq_l, irq_a, irq_b} === 3'b100, "R9 sel 11 to legacy", N'({irq_l, irq_a, irq_b}), N'(3'b100));
    wipe();
    rsel = '1;
    pin[100] = 1'b1;
    tick(); tick();
    chk({irq_l, irq_a, irq_b} === 3'b100, "R8 low pin to legacy", N'({irq_l, irq_a, irq_b}), N'(3'b100));
    wipe();

    // random traffic against the model
    for (int c = 0; c < 600; c++) begin
      if (c % 50 == 0) begin
        emode = {$urandom, $urandom, $urandom, $urandom};
        sense = {$urandom, $urandom, $urandom, $urandom};
        en    = {$urandom, $urandom, $urandom, $urandom};
        rsel  = $urandom;
      end
      pin = pin ^ ({$urandom, $urandom, $urandom, $urandom} &
                   {$urandom, $urandom, $urandom, $urandom});
      oe  = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
      clr = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
      tick();
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule